// File: doc/BRIEF.md
# Channel Fault and Diagnostic Logic

This block sits between the per-channel analog sensing of an eight-channel low-side switch and its serial readback register. Each channel brings in four digital flags: a command bit that asks for the switch to be on, a comparator flag that is set while the output voltage is above the diagnostic threshold, an overcurrent flag and an overtemperature flag. From these the block derives a gate drive per channel, a per-channel overload latch that forces the switch off, and one status bit per channel for the readback register. A status bit of 1 means healthy and 0 means a fault.

The channels split into two protection groups. The first six trip on overcurrent and are shut off at once. The last two ride through overcurrent, because an external regulator limits the current, and trip only on overtemperature. The status of the two lowest channels passes through a qualification filter and a fault latch that the active-low chip-select level clears. The status of the other six channels reaches the readback register live, with no register between them. Bit i of every vector belongs to channel i+1.

Top module: `chan_diag_top`

## Requirements
- R1: While rst_ni is low, ovld_o reads 8'h00 and status_o[1:0] reads 2'b11, whatever the inputs are.
- R2: On channels at bit positions 0 to 5, a clock edge that samples cmd_on_i and oc_i both high sets that channel's overload bit. The bit then stays set while the command stays high, even after oc_i falls.
- R3: On bit positions 6 and 7, oc_i never sets the overload bit. An edge that samples cmd_on_i and ot_i both high does set it.
- R4: An edge that samples cmd_on_i low clears that channel's overload bit. This clear wins over an overcurrent or overtemperature event in the same cycle.
- R5: gate_o[i] is high exactly when cmd_on_i[i] is high and ovld_o[i] is low.
- R6: For bit positions 2 to 7, status_o[i] is 0 in two cases: the command and the comparator are both high (short to supply, or current limiting), or both are low (open load, or short to ground). Otherwise it is 1, with no clock delay.
- R7: For bit positions 0 and 1, a raw fault sets the latched fault, and drives status_o[i] to 0, only after it has been sampled on 4 consecutive clock edges. A shorter run leaves status_o[i] at 1.
- R8: While cs_ni is high, a latched fault on bit 0 or 1 holds status_o[i] at 0 after the raw fault has gone away.
- R9: An edge that samples cs_ni low clears the latched fault on bits 0 and 1, even while a qualified raw fault is present. If that fault is still present, it latches again on the first edge that samples cs_ni high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip-select level, active low; clears the filtered fault latches |
| cmd_on_i | input | 8 | Commanded on state per channel |
| above_thr_i | input | 8 | Output above diagnostic threshold per channel |
| oc_i | input | 8 | Overcurrent flag per channel |
| ot_i | input | 8 | Overtemperature flag per channel |
| gate_o | output | 8 | Effective gate drive per channel |
| ovld_o | output | 8 | Overload latch state per channel |
| status_o | output | 8 | Diagnostic status per channel, 1 = no fault |

## Verification
The live status path is exercised with command and comparator patterns that place all four combinations on the live channels at once. These patterns separate an on-state fault from an off-state fault and from the two healthy cases. Overcurrent and overtemperature pulses are applied to both protection groups, each alone and together with a command drop in the same cycle. This shows which group trips on which flag and that the clear wins. On the filtered channels, a raw fault run of three edges is compared with a run of four. The bench then checks the hold while chip select is high, the clear while it is low, and the relatch when it rises.

// File: rtl/chan_diag_pkg.sv
package chan_diag_pkg;

  typedef enum logic {
    TRIP_OVERCURRENT = 1'b0,
    TRIP_THERMAL     = 1'b1
  } trip_mode_e;

  // on + high output, or off + low output, is a fault
  function automatic logic raw_fault(input logic cmd_on, input logic above);
    return cmd_on ? above : ~above;
  endfunction

endpackage

// File: rtl/diag_ovld_latch.sv
module diag_ovld_latch
  import chan_diag_pkg::*;
#(
  parameter trip_mode_e MODE = TRIP_OVERCURRENT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_on_i,
  input  logic oc_i,
  input  logic ot_i,
  output logic ovld_o
);

  logic trip;
  logic ovld_q;

  generate
    if (MODE == TRIP_OVERCURRENT) begin : g_oc
      assign trip = oc_i;
    end else begin : g_ot
      assign trip = ot_i;
    end
  endgenerate

  // command off clears, and clearing takes priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovld_q <= 1'b0;
    else if (!cmd_on_i) ovld_q <= 1'b0;
    else if (trip)      ovld_q <= 1'b1;
  end

  assign ovld_o = ovld_q;

endmodule

// File: rtl/diag_fault_filter.sv
module diag_fault_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic clr_i,
  output logic fault_o
);

  localparam int unsigned CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flt_q;
  logic             qual;

  assign qual = raw_i && (cnt_q == LAST);

  // consecutive-cycle counter, saturates at LAST
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!raw_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flt_q <= 1'b0;
    else if (clr_i)  flt_q <= 1'b0;
    else if (qual)   flt_q <= 1'b1;
  end

  assign fault_o = flt_q;

endmodule

// File: rtl/chan_diag_top.sv
module chan_diag_top
  import chan_diag_pkg::*;
#(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned N_OC_CH   = 6,
  parameter int unsigned N_FILT_CH = 2,
  parameter int unsigned FILT_LEN  = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic [N_CH-1:0] cmd_on_i,
  input  logic [N_CH-1:0] above_thr_i,
  input  logic [N_CH-1:0] oc_i,
  input  logic [N_CH-1:0] ot_i,
  output logic [N_CH-1:0] gate_o,
  output logic [N_CH-1:0] ovld_o,
  output logic [N_CH-1:0] status_o
);

  logic [N_CH-1:0] raw;
  logic [N_CH-1:0] ovld;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam trip_mode_e MODE = (i < N_OC_CH) ? TRIP_OVERCURRENT : TRIP_THERMAL;

    assign raw[i] = raw_fault(cmd_on_i[i], above_thr_i[i]);

    diag_ovld_latch #(.MODE(MODE)) u_ovld (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cmd_on_i (cmd_on_i[i]),
      .oc_i     (oc_i[i]),
      .ot_i     (ot_i[i]),
      .ovld_o   (ovld[i])
    );

    assign gate_o[i] = cmd_on_i[i] & ~ovld[i];

    if (i < N_FILT_CH) begin : g_filt
      logic flt;
      diag_fault_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .raw_i   (raw[i]),
        .clr_i   (~cs_ni),
        .fault_o (flt)
      );
      assign status_o[i] = ~flt;
    end else begin : g_live
      assign status_o[i] = ~raw[i];
    end
  end

  assign ovld_o = ovld;

endmodule

// File: rtl/chan_diag_chk.sv
module chan_diag_chk #(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned N_OC_CH   = 6,
  parameter int unsigned N_FILT_CH = 2,
  parameter int unsigned FILT_LEN  = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_ni,
  input logic [N_CH-1:0] cmd_on_i,
  input logic [N_CH-1:0] above_thr_i,
  input logic [N_CH-1:0] oc_i,
  input logic [N_CH-1:0] ot_i,
  input logic [N_CH-1:0] gate_o,
  input logic [N_CH-1:0] ovld_o,
  input logic [N_CH-1:0] status_o
);

  for (genvar i = 0; i < N_CH; i++) begin : g_a
    assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmd_on_i[i] |=> !ovld_o[i]);

    assert_gate_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovld_o[i] || !cmd_on_i[i]) |-> !gate_o[i]);

    if (i < N_OC_CH) begin : g_oc
      assert_oc_trip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_on_i[i] && oc_i[i]) |=> ovld_o[i]);
    end else begin : g_ot
      assert_oc_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ovld_o[i] && !ot_i[i]) |=> !ovld_o[i]);
      assert_ot_trip_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_on_i[i] && ot_i[i]) |=> ovld_o[i]);
    end

    if (i < N_FILT_CH) begin : g_filt
      logic raw;
      int unsigned run_q;
      assign raw = cmd_on_i[i] ? above_thr_i[i] : ~above_thr_i[i];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               run_q <= 0;
        else if (!raw)             run_q <= 0;
        else if (run_q < FILT_LEN) run_q <= run_q + 1;
      end

      assert_filter_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[i]) |-> (run_q >= FILT_LEN));

      assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_ni && !status_o[i]) |=> !status_o[i]);

      assert_cs_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cs_ni |=> status_o[i]);
    end else begin : g_live
      assert_live_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_on_i[i] == above_thr_i[i]) |-> !status_o[i]);
      assert_live_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_on_i[i] != above_thr_i[i]) |-> status_o[i]);
    end
  end

endmodule

bind chan_diag_top chan_diag_chk #(
  .N_CH(N_CH), .N_OC_CH(N_OC_CH), .N_FILT_CH(N_FILT_CH), .FILT_LEN(FILT_LEN)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .cmd_on_i    (cmd_on_i),
  .above_thr_i (above_thr_i),
  .oc_i        (oc_i),
  .ot_i        (ot_i),
  .gate_o      (gate_o),
  .ovld_o      (ovld_o),
  .status_o    (status_o)
);

// File: tb/sim_chan_diag_top.sv
module sim_chan_diag_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic [7:0] cmd_on_i = 8'h00;
  logic [7:0] above_thr_i = 8'hFF;
  logic [7:0] oc_i = 8'h00;
  logic [7:0] ot_i = 8'h00;
  logic [7:0] gate_o, ovld_o, status_o;

  int  n_vec = 0;
  int  n_err = 0;
  bit  done = 1'b0;

  always #10 clk_i = ~clk_i;

  chan_diag_top u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
    .cmd_on_i(cmd_on_i), .above_thr_i(above_thr_i),
    .oc_i(oc_i), .ot_i(ot_i),
    .gate_o(gate_o), .ovld_o(ovld_o), .status_o(status_o)
  );

  // {cmd, above, expected status & 8'hFC, expected gate}
  localparam logic [31:0] VEC [8] = '{
    {8'hFF, 8'h00, 8'hFC, 8'hFF},
    {8'hFF, 8'hFF, 8'h00, 8'hFF},
    {8'h00, 8'hFF, 8'hFC, 8'h00},
    {8'h00, 8'h00, 8'h00, 8'h00},
    {8'hA5, 8'h0F, 8'hA8, 8'hA5},
    {8'h3C, 8'h5A, 8'h64, 8'h3C},
    {8'hF0, 8'h33, 8'hC0, 8'hF0},
    {8'h0F, 8'h0F, 8'h00, 8'h0F}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got %h expected %h", 8'h00, 8'h01);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tick(2);
    chk("R1 ovld in reset", ovld_o, 8'h00);
    chk("R1 filtered status in reset", status_o & 8'h03, 8'h03);
    rst_ni = 1'b1;

    // R6/R5: vector table, chip select low so filtered bits stay clear
    cs_ni = 1'b0;
    for (int v = 0; v < 8; v++) begin
      cmd_on_i    = VEC[v][31:24];
      above_thr_i = VEC[v][23:16];
      #1;
      chk("R6 live status", status_o & 8'hFC, VEC[v][15:8]);
      chk("R5 gate", gate_o, VEC[v][7:0]);
      tick();
    end

    // healthy baseline
    cs_ni = 1'b1; cmd_on_i = 8'hFF; above_thr_i = 8'h00;
    tick();
    chk("R6 no-fault status", status_o, 8'hFF);

    // R2: overcurrent trip on channel bit 2
    oc_i = 8'h04;
    tick();
    oc_i = 8'h00;
    chk("R2 oc trip", ovld_o, 8'h04);
    chk("R5 gate forced off", gate_o, 8'hFB);
    tick();
    chk("R2 latch holds", ovld_o, 8'h04);

    // R4: command off clears, beats simultaneous overcurrent
    cmd_on_i = 8'hFB; oc_i = 8'h04;
    tick();
    chk("R4 clear over oc", ovld_o, 8'h00);
    cmd_on_i = 8'hFF; oc_i = 8'h00;
    tick();
    chk("R5 gate restored", gate_o, 8'hFF);

    // R3: overcurrent ignored on bits 6,7; overtemperature trips
    oc_i = 8'hC0;
    tick();
    oc_i = 8'h00;
    chk("R3 oc ignored", ovld_o, 8'h00);
    ot_i = 8'h40;
    tick();
    ot_i = 8'h00;
    chk("R3 ot trip", ovld_o, 8'h40);
    chk("R5 gate thermal off", gate_o, 8'hBF);

    // R4: clear beats overtemperature
    cmd_on_i = 8'h3F; ot_i = 8'h80;
    tick();
    chk("R4 clear over ot", ovld_o, 8'h00);
    cmd_on_i = 8'hFF; ot_i = 8'h00;
    tick();

    // R7: run of 3 does not latch
    above_thr_i = 8'h01;
    tick(3);
    chk("R7 three edges", status_o & 8'h03, 8'h03);
    above_thr_i = 8'h00;
    tick();
    chk("R7 broken run", status_o & 8'h03, 8'h03);

    // R7: run of 4 latches
    above_thr_i = 8'h01;
    tick(3);
    chk("R7 before fourth", status_o & 8'h03, 8'h03);
    tick();
    chk("R7 fourth edge", status_o & 8'h03, 8'h02);

    // R8: hold after raw fault goes away
    above_thr_i = 8'h00;
    tick(3);
    chk("R8 hold", status_o & 8'h03, 8'h02);

    // R9: chip select low clears
    cs_ni = 1'b0;
    tick();
    chk("R9 clear", status_o & 8'h03, 8'h03);

    // R9: clear wins over a qualified fault, relatch when cs rises
    above_thr_i = 8'h02;
    tick(6);
    chk("R9 clear wins", status_o & 8'h03, 8'h03);
    cs_ni = 1'b1;
    tick();
    chk("R9 relatch", status_o & 8'h03, 8'h01);

    // R1: asynchronous reset with state present
    above_thr_i = 8'h00; oc_i = 8'h01;
    tick();
    oc_i = 8'h00;
    chk("R2 bit0 trip", ovld_o, 8'h01);
    rst_ni = 1'b0;
    #1;
    chk("R1 async ovld", ovld_o, 8'h00);
    chk("R1 async status", status_o & 8'h03, 8'h03);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule